// File: doc/BRIEF.md
# Vector Length and Type Configuration Unit

This unit runs the instructions that configure a vector engine's element width, register grouping and active length. Each incoming item is a 32-bit instruction word that is already known to be a configuration instruction, with the scalar value read for its first source register and, for the all-register form, the value read for its second source register. The unit identifies which of three encodings the word uses and picks out the requested type setting and requested length (AVL). It derives the maximum element count for that type and checks the type for reserved codes. It then updates its length and type state. The new length is returned as the value for the destination register.

Three encodings are handled. The first takes its type from an immediate and its length from a register. The second takes both from registers. The third takes its type from a shorter immediate and its length from a 5-bit immediate. For the two register-length forms, a length above the maximum is cut down to the maximum. For the immediate-length form, a length above the maximum is not cut down. Instead the configuration is marked illegal, so that a software mistake becomes visible.

Instructions arrive on a valid/ready stream and results leave on a valid/ready stream. An item is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while an earlier result is still held and `out_ready` is low. While `out_valid` is high and `out_ready` is low, the result fields do not change. The configuration state outputs are plain status pins.

Top module: `vcfg_unit`

## Requirements
- R1: The form is taken from the instruction bits. If bit 31 is 0, the type comes from bits [30:20] and the AVL from the first source value. If bits [31:30] are 2'b11, the type comes from bits [29:20] and the AVL from bits [19:15]. If bits [31:25] are 7'b1000000, the type comes from the second source value and the AVL from the first source value. Any other pattern gives an illegal configuration.
- R2: The type value is laid out as follows. Grouping code in [2:0]: 000=1, 001=2, 010=4, 011=8, 101=1/8, 110=1/4, 111=1/2, and 100 is reserved. Width code in [5:3]: 000=8, 001=16, 010=32, 011=64 bits, and any higher code is reserved. Tail policy in [6], mask policy in [7]. Every bit above 7 must be zero. A reserved code, a nonzero upper bit, or an element width above the parameter ELEN gives an illegal configuration.
- R3: The maximum count is VLMAX = VLEN × grouping / width. A type for which this value falls below 1 is illegal.
- R4: For the two register-length forms, the new length is min(AVL, VLMAX).
- R5: The immediate AVL is zero-extended, and the code 5'b00000 means 32.
- R6: In the immediate-length form, an AVL above VLMAX gives an illegal configuration and is never cut down.
- R7: For an illegal configuration, `cfg_vill` is 1, `cfg_vtype` is 0, and both `cfg_vl` and `out_vl` are 0.
- R8: For a legal configuration, `cfg_vill` is 0 and `cfg_vtype` holds type bits [7:0] unchanged.
- R9: Result timing. The result and the new state appear in the cycle after acceptance. `out_rd` is instruction bits [11:7]. While stalled, `out_valid`, `out_vl` and `out_rd` hold steady. `in_ready` equals `!out_valid || out_ready`.
- R10: After reset, `out_valid` is 0, `cfg_vill` is 1, `cfg_vl` is 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction item offered |
| in_ready | output | 1 | Unit can take an item this cycle |
| in_instr | input | 32 | Configuration instruction word |
| in_rs1_val | input | XLEN | First source value (AVL for register-length forms) |
| in_rs2_val | input | XLEN | Second source value (type for the all-register form) |
| out_valid | output | 1 | Destination write offered |
| out_ready | input | 1 | Consumer takes the destination write |
| out_rd | output | 5 | Destination register index |
| out_vl | output | XLEN | New length for the destination register |
| cfg_vl | output | $clog2(VLEN)+1 | Current length state |
| cfg_vtype | output | 8 | Current type fields |
| cfg_vill | output | 1 | Current configuration is illegal |

## Verification
The assertions assume three things. The instruction word and its operands matter only in a cycle where `in_valid` is high. `out_ready` is the only thing that stalls the output. The type fields and the AVL seen at acceptance are the ones the clamp and overrun checks refer to. The stimulus holds each word and its operands steady until it is accepted. It drives `out_ready` randomly only during a dedicated back-pressure phase. It deliberately includes reserved codes, nonzero upper type bits, and an unknown form pattern, so that each illegal path is reached.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    FORM_IMM_TYPE = 2'd0,
    FORM_IMM_AVL  = 2'd1,
    FORM_REG_REG  = 2'd2,
    FORM_UNKNOWN  = 2'd3
  } vcfg_form_e;

  localparam int VTYPE_W = 8;

  typedef struct packed {
    logic       mask_pol;
    logic       tail_pol;
    logic [2:0] width_code;
    logic [2:0] group_code;
  } vtype_t;

  localparam int IMM_AVL_ZERO_MEANS = 32;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output vcfg_form_e      form,
  output logic [XLEN-1:0] avl,
  output logic [XLEN-1:0] vtype_raw
);

  localparam int PAD11 = XLEN - 11;
  localparam int PAD10 = XLEN - 10;

  logic [4:0] uimm;
  logic       unused_bits;

  assign uimm        = instr[19:15];
  assign unused_bits = ^{instr[14:12], instr[6:0]};

  always_comb begin
    if (!instr[31]) begin
      form = FORM_IMM_TYPE;
    end else if (instr[30]) begin
      form = FORM_IMM_AVL;
    end else if (instr[31:25] == 7'b1000000) begin
      form = FORM_REG_REG;
    end else begin
      form = FORM_UNKNOWN;
    end
  end

  always_comb begin
    unique case (form)
      FORM_IMM_TYPE: vtype_raw = {{PAD11{1'b0}}, instr[30:20]};
      FORM_IMM_AVL:  vtype_raw = {{PAD10{1'b0}}, instr[29:20]};
      FORM_REG_REG:  vtype_raw = rs2_val;
      default:       vtype_raw = '0;
    endcase
  end

  always_comb begin
    if (form == FORM_IMM_AVL) begin
      avl = (uimm == 5'd0) ? XLEN'(IMM_AVL_ZERO_MEANS) : XLEN'(uimm);
    end else begin
      avl = rs1_val;
    end
  end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64
) (
  input  logic [XLEN-1:0]          vtype_raw,
  output logic [$clog2(VLEN):0]    vlmax,
  output logic                     legal
);

  localparam int LOG_VLEN = $clog2(VLEN);
  localparam int VLW      = LOG_VLEN + 1;
  localparam int NSEW     = 4;

  vtype_t     vt;
  logic       upper_set;
  logic       group_bad;
  logic       width_bad;
  logic [7:0] group_exp;
  logic [7:0] count_exp;
  logic [NSEW-1:0] sew_fits;

  assign vt        = vtype_t'(vtype_raw[VTYPE_W-1:0]);
  assign upper_set = |vtype_raw[XLEN-1:VTYPE_W];

  for (genvar s = 0; s < NSEW; s++) begin : g_sew
    assign sew_fits[s] = ((8 << s) <= ELEN);
  end

  always_comb begin
    group_bad = 1'b0;
    unique case (vt.group_code)
      3'b000:  group_exp = 8'd0;
      3'b001:  group_exp = 8'd1;
      3'b010:  group_exp = 8'd2;
      3'b011:  group_exp = 8'd3;
      3'b101:  group_exp = 8'hFD;
      3'b110:  group_exp = 8'hFE;
      3'b111:  group_exp = 8'hFF;
      default: begin
        group_exp = 8'd0;
        group_bad = 1'b1;
      end
    endcase
  end

  assign width_bad = vt.width_code[2] || !sew_fits[vt.width_code[1:0]];

  always_comb begin
    count_exp = 8'(LOG_VLEN) + group_exp - 8'd3 - {5'd0, vt.width_code};
    vlmax     = count_exp[7] ? '0 : (VLW'(1) << count_exp[6:0]);
  end

  assign legal = !upper_set && !group_bad && !width_bad && !count_exp[7];

endmodule

// File: rtl/vcfg_len.sv
module vcfg_len
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLW  = 8
) (
  input  vcfg_form_e      form,
  input  logic [XLEN-1:0] avl,
  input  logic [VLW-1:0]  vlmax,
  input  logic            type_legal,
  output logic [VLW-1:0]  new_vl,
  output logic            new_vill
);

  logic over;

  assign over = avl > XLEN'(vlmax);

  always_comb begin
    new_vill = 1'b0;
    new_vl   = '0;
    if (!type_legal || form == FORM_UNKNOWN) begin
      new_vill = 1'b1;
    end else if (form == FORM_IMM_AVL) begin
      if (over) begin
        new_vill = 1'b1;
      end else begin
        new_vl = VLW'(avl);
      end
    end else begin
      new_vl = over ? vlmax : VLW'(avl);
    end
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [31:0]            in_instr,
  input  logic [XLEN-1:0]        in_rs1_val,
  input  logic [XLEN-1:0]        in_rs2_val,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [4:0]             out_rd,
  output logic [XLEN-1:0]        out_vl,
  output logic [$clog2(VLEN):0]  cfg_vl,
  output logic [VTYPE_W-1:0]     cfg_vtype,
  output logic                   cfg_vill
);

  localparam int VLW = $clog2(VLEN) + 1;

  vcfg_form_e      form;
  logic [XLEN-1:0] avl;
  logic [XLEN-1:0] vtype_raw;
  logic [VLW-1:0]  vlmax;
  logic            type_legal;
  logic [VLW-1:0]  new_vl;
  logic            new_vill;
  logic            accept;

  logic [VLW-1:0]     vl_q;
  logic [VTYPE_W-1:0] vtype_q;
  logic               vill_q;
  logic               valid_q;
  logic [4:0]         rd_q;

  vcfg_decode #(.XLEN(XLEN)) u_dec (
    .instr     (in_instr),
    .rs1_val   (in_rs1_val),
    .rs2_val   (in_rs2_val),
    .form      (form),
    .avl       (avl),
    .vtype_raw (vtype_raw)
  );

  vcfg_vlmax #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_max (
    .vtype_raw (vtype_raw),
    .vlmax     (vlmax),
    .legal     (type_legal)
  );

  vcfg_len #(.XLEN(XLEN), .VLW(VLW)) u_len (
    .form       (form),
    .avl        (avl),
    .vlmax      (vlmax),
    .type_legal (type_legal),
    .new_vl     (new_vl),
    .new_vill   (new_vill)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      vtype_q <= '0;
      vill_q  <= 1'b1;
      valid_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        vl_q    <= new_vill ? '0 : new_vl;
        vtype_q <= new_vill ? '0 : vtype_raw[VTYPE_W-1:0];
        vill_q  <= new_vill;
        rd_q    <= in_instr[11:7];
        valid_q <= 1'b1;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_rd    = rd_q;
  assign out_vl    = XLEN'(vl_q);
  assign cfg_vl    = vl_q;
  assign cfg_vtype = vtype_q;
  assign cfg_vill  = vill_q;

  // R7: an illegal state carries no length and no type fields
  p_illegal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vill |-> (cfg_vl == '0 && cfg_vtype == '0));

  // R6: an immediate length above the maximum is flagged, never cut down
  p_imm_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && form == FORM_IMM_AVL && avl > XLEN'(vlmax)) |=> cfg_vill);

  // R4: register-length forms cut the length to the maximum
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && type_legal && form != FORM_IMM_AVL && form != FORM_UNKNOWN
     && avl >= XLEN'(vlmax)) |=> (!cfg_vill && cfg_vl == $past(vlmax)));

  // R9: result appears the cycle after acceptance
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R9: a stalled result holds steady
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vl) && $stable(out_rd)));

  // R3: a legal type yields a power-of-two maximum
  p_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && type_legal) |-> $onehot(vlmax));

endmodule

// File: tb/sim_vcfg_unit.sv
`timescale 1ns/1ps
module sim_vcfg_unit;

  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VLW  = $clog2(VLEN) + 1;

  typedef struct {
    int         vl;
    logic       vill;
    logic [7:0] vt;
    logic [4:0] rd;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_instr = '0;
  logic [XLEN-1:0] in_rs1_val = '0;
  logic [XLEN-1:0] in_rs2_val = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4:0] out_rd;
  logic [XLEN-1:0] out_vl;
  logic [VLW-1:0] cfg_vl;
  logic [7:0] cfg_vtype;
  logic cfg_vill;

  int n_tests = 0;
  int n_fail = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd), .out_vl(out_vl),
    .cfg_vl(cfg_vl), .cfg_vtype(cfg_vtype), .cfg_vill(cfg_vill)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] i_immtype(logic [10:0] z, logic [4:0] rs1, logic [4:0] rd);
    return {1'b0, z, rs1, 3'b111, rd, 7'h57};
  endfunction

  function automatic logic [31:0] i_immavl(logic [9:0] z, logic [4:0] u, logic [4:0] rd);
    return {2'b11, z, u, 3'b111, rd, 7'h57};
  endfunction

  function automatic logic [31:0] i_regreg(logic [6:0] top7, logic [4:0] rd);
    return {top7, 5'd2, 5'd1, 3'b111, rd, 7'h57};
  endfunction

  function automatic exp_t model(logic [31:0] ins, logic [31:0] r1, logic [31:0] r2, string tag);
    exp_t e;
    logic [31:0] raw;
    int avl;
    int form;
    int lm;
    int ex;
    int vmax;
    bit ok;
    if (!ins[31]) begin form = 0; raw = {21'd0, ins[30:20]}; avl = int'(r1); end
    else if (ins[31:30] == 2'b11) begin
      form = 1; raw = {22'd0, ins[29:20]};
      avl = (ins[19:15] == 0) ? 32 : int'(ins[19:15]);
    end else if (ins[31:25] == 7'b1000000) begin form = 2; raw = r2; avl = int'(r1); end
    else begin form = 3; raw = '0; avl = 0; end
    ok = (form != 3) && (raw[31:8] == 0) && (raw[2:0] != 3'b100) && (raw[5:3] <= 3);
    case (raw[2:0])
      3'b101: lm = -3;
      3'b110: lm = -2;
      3'b111: lm = -1;
      default: lm = int'(raw[1:0]);
    endcase
    ex = 7 + lm - 3 - int'(raw[5:3]);
    if (ex < 0) ok = 0;
    vmax = ok ? (1 << ex) : 0;
    e.vl = 0;
    if (ok) begin
      if (form == 1) begin
        if (avl > vmax) ok = 0; else e.vl = avl;
      end else begin
        e.vl = (avl > vmax) ? vmax : avl;
      end
    end
    e.vill = !ok;
    e.vt = ok ? raw[7:0] : 8'd0;
    e.rd = ins[11:7];
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [31:0] ins, logic [31:0] r1, logic [31:0] r2, string tag);
    bit fire;
    q.push_back(model(ins, r1, r2, tag));
    in_instr = ins;
    in_rs1_val = r1;
    in_rs2_val = r2;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      fire = in_ready;
      @(posedge clk);
      #1;
      if (fire) break;
    end
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
  end

  bit stall_prev = 1'b0;
  logic [XLEN-1:0] held_vl;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        chk("R9", "held valid", out_valid, 1);
        chk("R9", "held vl", out_vl, held_vl);
      end
      stall_prev = out_valid && !out_ready;
      held_vl = out_vl;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R9", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "out_vl", out_vl, e.vl);
          chk(e.tag, "cfg_vl", cfg_vl, e.vl);
          chk(e.tag, "cfg_vill", cfg_vill, e.vill);
          chk(e.tag, "cfg_vtype", cfg_vtype, e.vt);
          chk("R9", "out_rd", out_rd, e.rd);
        end
      end
    end
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", out_valid, 0);
    chk("R10", "cfg_vill", cfg_vill, 1);
    chk("R10", "cfg_vl", cfg_vl, 0);
    chk("R10", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R4 R8: type immediate, e8 m1 (VLMAX 16)
    send(i_immtype(11'h000, 5'd1, 5'd3), 32'd5, 32'd0, "R4");
    send(i_immtype(11'h000, 5'd1, 5'd4), 32'd100, 32'd0, "R4");
    // e32 m8: VLMAX 32, clamp from 1000
    send(i_immtype(11'h013, 5'd1, 5'd5), 32'd1000, 32'd0, "R4");
    // e16 mf2 with both policies: VLMAX 4
    send(i_immtype(11'h0CF, 5'd1, 5'd6), 32'd3, 32'd0, "R8");
    // R3: e64 mf8 -> below one element
    send(i_immtype(11'h01D, 5'd1, 5'd7), 32'd4, 32'd0, "R3");
    // R2: reserved grouping, reserved width, upper bit set
    send(i_immtype(11'h004, 5'd1, 5'd8), 32'd4, 32'd0, "R2");
    send(i_immtype(11'h028, 5'd1, 5'd9), 32'd4, 32'd0, "R2");
    send(i_immtype(11'h100, 5'd1, 5'd10), 32'd4, 32'd0, "R2");
    // R5: zero code means 32; e8 m2 VLMAX 32 -> 32
    send(i_immavl(10'h001, 5'd0, 5'd11), 32'd7, 32'd0, "R5");
    // R6: zero code with e8 m1 VLMAX 16 -> illegal
    send(i_immavl(10'h000, 5'd0, 5'd12), 32'd0, 32'd0, "R6");
    send(i_immavl(10'h000, 5'd17, 5'd13), 32'd0, 32'd0, "R6");
    send(i_immavl(10'h000, 5'd16, 5'd14), 32'd0, 32'd0, "R5");
    send(i_immavl(10'h018, 5'd3, 5'd15), 32'd0, 32'd0, "R6");
    send(i_immavl(10'h200, 5'd2, 5'd16), 32'd0, 32'd0, "R2");
    // R1: register form, type from second source
    send(i_regreg(7'b1000000, 5'd17), 32'd9, 32'h0000_00D1, "R1");
    send(i_regreg(7'b1000000, 5'd18), 32'd9, 32'h8000_0000, "R7");
    send(i_regreg(7'b1000001, 5'd19), 32'd9, 32'd0, "R1");
    // legal again after illegal
    send(i_immtype(11'h008, 5'd1, 5'd20), 32'd6, 32'd0, "R8");

    // R9: back-pressure phase
    bp_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r1;
      logic [2:0] w;
      logic [2:0] g;
      r1 = $urandom % 80;
      w = 3'($urandom % 5);
      g = 3'($urandom % 8);
      if (i % 3 == 0)
        send(i_immavl({4'd0, w, g}, 5'($urandom), 5'(i)), 32'd0, 32'd0, "R6");
      else if (i % 3 == 1)
        send(i_immtype({5'd0, w, g}, 5'd1, 5'(i)), r1, 32'd0, "R4");
      else
        send(i_regreg(7'b1000000, 5'(i)), r1, {24'd0, 2'b01, w, g}, "R1");
    end
    bp_on = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk("R9", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule